// File: doc/BRIEF.md
# Interrupt-Banked General Register File

This block is a general-purpose register file with two combinational read ports and one synchronous write port. Each entry holds a data word and a one-bit deferred-exception tag. A contiguous window of registers (16 to 31 by default) exists in two physical copies. Every other register exists once and is visible whatever the bank selection.

A one-bit bank selector picks which copy of the window reads and writes reach. Taking an interrupt forces the selector to bank 0. This gives the handler a private set of scratch registers without any save sequence. Before the selector is cleared, its current value is copied into a saved-bank register. An interrupt return restores the selector from that saved copy. An explicit switch command sets the selector to the bank it names.

Any bank change is applied at the clock edge where the event is seen. A write issued in that same cycle still lands in the bank that was active before the edge.

Top module: `banked_gpr_file`

## Requirements
- R1: After reset, every register reads data 0 with tag 0, the bank selector is 0 and the saved bank is 0.
- R2: Register 0 always reads data 0 with tag 0, and a write to register 0 changes nothing.
- R3: When `intr_take_i` is high at a clock edge, `bank_o` is 0 from the next cycle on.
- R4: When `intr_ret_i` is high and `intr_take_i` is low at a clock edge, `bank_o` takes the value that `saved_bank_o` held before that edge.
- R5: When `bank_sw_i` is high and both `intr_take_i` and `intr_ret_i` are low at a clock edge, `bank_o` takes the value of `bank_sw_sel_i`.
- R6: When `intr_take_i` is high at a clock edge, `saved_bank_o` takes the value `bank_o` held before the edge. In all other cycles `saved_bank_o` holds its value.
- R7: Priority is interrupt entry, then interrupt return, then switch command. With none of the three asserted, `bank_o` holds its value.
- R8: Registers in the banked window (16 to 31) have one copy per bank value (0 and 1). Reads and writes use the copy selected by `bank_o` in the cycle of the access. All other registers are shared by both banks.
- R9: The tag bit is written and read with its data word, and the tag is banked together with the data.
- R10: The two read ports return independent registers combinationally. A write becomes visible to reads only in the cycle after its clock edge, with no write-to-read bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_a_addr_i | input | 5 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_a_tag_o | output | 1 | Read port A deferred-exception tag |
| rd_b_addr_i | input | 5 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| rd_b_tag_o | output | 1 | Read port B deferred-exception tag |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register index |
| wr_data_i | input | 32 | Write data |
| wr_tag_i | input | 1 | Write tag |
| intr_take_i | input | 1 | Interrupt entry event |
| intr_ret_i | input | 1 | Interrupt return event |
| bank_sw_i | input | 1 | Explicit bank switch command |
| bank_sw_sel_i | input | 1 | Bank named by the switch command |
| bank_o | output | 1 | Active bank selector |
| saved_bank_o | output | 1 | Bank selector saved at interrupt entry |

## Verification
A vector walk alternates switch commands with writes to the window edges (16 and 31), to an unbanked neighbour (15) and to register 0. This separates a correctly banked copy from a shared one and shows whether the tag follows its data across bank changes. One write is issued in the same cycle as a switch, which exposes a design that applies the new bank to that write too early. Directed cases then drive simultaneous interrupt-and-switch and return-and-switch pairs to pin down priority. Further cases use a write coinciding with interrupt entry and a same-cycle read of a pending write to expose any bypass.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  typedef enum logic [1:0] {
    EVT_NONE,
    EVT_INTR,
    EVT_RET,
    EVT_SW
  } bank_evt_e;
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
  import banked_rf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic intr_take_i,
  input  logic intr_ret_i,
  input  logic bank_sw_i,
  input  logic bank_sw_sel_i,
  output logic bank_o,
  output logic saved_bank_o
);
  bank_evt_e evt;
  logic      bank_q, saved_q;

  // interrupt entry outranks return, return outranks switch
  always_comb begin
    if (intr_take_i)     evt = EVT_INTR;
    else if (intr_ret_i) evt = EVT_RET;
    else if (bank_sw_i)  evt = EVT_SW;
    else                 evt = EVT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= 1'b0;
      saved_q <= 1'b0;
    end else begin
      unique case (evt)
        EVT_INTR: begin
          saved_q <= bank_q;
          bank_q  <= 1'b0;
        end
        EVT_RET:  bank_q <= saved_q;
        EVT_SW:   bank_q <= bank_sw_sel_i;
        default:  ;
      endcase
    end
  end

  assign bank_o       = bank_q;
  assign saved_bank_o = saved_q;
endmodule

// File: rtl/rf_addr_map.sv
module rf_addr_map #(
  parameter int ADDR_W   = 5,
  parameter int PHYS_W   = 6,
  parameter int NUM_REGS = 32,
  parameter int BANK_LO  = 16,
  parameter int BANK_HI  = 31
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bank_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic in_window;

  assign in_window = (addr_i >= ADDR_W'(BANK_LO)) && (addr_i <= ADDR_W'(BANK_HI));

  // bank 1 copies of the window sit after the architectural registers
  assign phys_o = (in_window && bank_i)
                ? PHYS_W'(NUM_REGS) + PHYS_W'(addr_i) - PHYS_W'(BANK_LO)
                : PHYS_W'(addr_i);
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W = 32,
  parameter int PHYS_N = 48,
  parameter int PHYS_W = 6,
  parameter int N_RD   = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [PHYS_W-1:0]            wr_phys_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic                         wr_tag_i,
  input  logic [N_RD-1:0][PHYS_W-1:0]  rd_phys_i,
  output logic [N_RD-1:0][DATA_W-1:0]  rd_data_o,
  output logic [N_RD-1:0]              rd_tag_o
);
  logic [DATA_W-1:0] data_q [PHYS_N];
  logic              tag_q  [PHYS_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS_N; i++) begin
        data_q[i] <= '0;
        tag_q[i]  <= 1'b0;
      end
    end else if (wr_en_i) begin
      data_q[wr_phys_i] <= wr_data_i;
      tag_q[wr_phys_i]  <= wr_tag_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_data_o[p] = data_q[rd_phys_i[p]];
    assign rd_tag_o[p]  = tag_q[rd_phys_i[p]];
  end
endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int BANK_LO  = 16,
  parameter int BANK_HI  = 31,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic              rd_a_tag_o,
  input  logic [ADDR_W-1:0] rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic              rd_b_tag_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_tag_i,
  input  logic              intr_take_i,
  input  logic              intr_ret_i,
  input  logic              bank_sw_i,
  input  logic              bank_sw_sel_i,
  output logic              bank_o,
  output logic              saved_bank_o
);
  localparam int BANK_CNT = BANK_HI - BANK_LO + 1;
  localparam int PHYS_N   = NUM_REGS + BANK_CNT;
  localparam int PHYS_W   = $clog2(PHYS_N);
  localparam int N_PORTS  = 3;  // two reads, then the write

  logic                          bank;
  logic [N_PORTS-1:0][ADDR_W-1:0] arch_addr;
  logic [N_PORTS-1:0][PHYS_W-1:0] phys_addr;
  logic [1:0][DATA_W-1:0]         rd_data;
  logic [1:0]                     rd_tag;
  logic                           wr_ok;

  rf_bank_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .intr_take_i  (intr_take_i),
    .intr_ret_i   (intr_ret_i),
    .bank_sw_i    (bank_sw_i),
    .bank_sw_sel_i(bank_sw_sel_i),
    .bank_o       (bank),
    .saved_bank_o (saved_bank_o)
  );

  assign arch_addr[0] = rd_a_addr_i;
  assign arch_addr[1] = rd_b_addr_i;
  assign arch_addr[2] = wr_addr_i;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    rf_addr_map #(
      .ADDR_W  (ADDR_W),
      .PHYS_W  (PHYS_W),
      .NUM_REGS(NUM_REGS),
      .BANK_LO (BANK_LO),
      .BANK_HI (BANK_HI)
    ) u_map (
      .addr_i(arch_addr[p]),
      .bank_i(bank),
      .phys_o(phys_addr[p])
    );
  end

  // register 0 is never stored, so it keeps its reset value of zero
  assign wr_ok = wr_en_i && (wr_addr_i != '0);

  rf_storage #(
    .DATA_W(DATA_W),
    .PHYS_N(PHYS_N),
    .PHYS_W(PHYS_W),
    .N_RD  (2)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_ok),
    .wr_phys_i(phys_addr[2]),
    .wr_data_i(wr_data_i),
    .wr_tag_i (wr_tag_i),
    .rd_phys_i(phys_addr[1:0]),
    .rd_data_o(rd_data),
    .rd_tag_o (rd_tag)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_a_tag_o  = rd_tag[0];
  assign rd_b_data_o = rd_data[1];
  assign rd_b_tag_o  = rd_tag[1];
  assign bank_o      = bank;
endmodule

// File: rtl/rf_bank_checker.sv
module rf_bank_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rd_a_addr_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic              rd_a_tag_o,
  input logic [ADDR_W-1:0] rd_b_addr_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              rd_b_tag_o,
  input logic              intr_take_i,
  input logic              intr_ret_i,
  input logic              bank_sw_i,
  input logic              bank_sw_sel_i,
  input logic              bank_o,
  input logic              saved_bank_o
);
  p_intr_bank0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_take_i |=> !bank_o);

  p_ret_restore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_ret_i && !intr_take_i) |=> bank_o == $past(saved_bank_o));

  p_sw_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_sw_i && !intr_take_i && !intr_ret_i) |=> bank_o == $past(bank_sw_sel_i));

  p_save_on_intr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_take_i |=> saved_bank_o == $past(bank_o));

  p_saved_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !intr_take_i |=> $stable(saved_bank_o));

  p_bank_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(intr_take_i || intr_ret_i || bank_sw_i) |=> $stable(bank_o));

  p_zero_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0 && !rd_a_tag_o));

  p_zero_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == '0) |-> (rd_b_data_o == '0 && !rd_b_tag_o));
endmodule

bind banked_gpr_file rf_bank_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_a_addr_i  (rd_a_addr_i),
  .rd_a_data_o  (rd_a_data_o),
  .rd_a_tag_o   (rd_a_tag_o),
  .rd_b_addr_i  (rd_b_addr_i),
  .rd_b_data_o  (rd_b_data_o),
  .rd_b_tag_o   (rd_b_tag_o),
  .intr_take_i  (intr_take_i),
  .intr_ret_i   (intr_ret_i),
  .bank_sw_i    (bank_sw_i),
  .bank_sw_sel_i(bank_sw_sel_i),
  .bank_o       (bank_o),
  .saved_bank_o (saved_bank_o)
);

// File: tb/banked_gpr_file_test.sv
module banked_gpr_file_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic        rd_a_tag_o, rd_b_tag_o, wr_tag_i = 1'b0, wr_en_i = 1'b0;
  logic        intr_take_i = 1'b0, intr_ret_i = 1'b0;
  logic        bank_sw_i = 1'b0, bank_sw_sel_i = 1'b0;
  logic        bank_o, saved_bank_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  banked_gpr_file uut (.*);

  typedef struct packed {
    logic        sw;
    logic        sel;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        wt;
    logic [4:0]  ra;
    logic [31:0] ed;
    logic        et;
    logic        eb;
  } vec_t;

  // expectations are the state after the clock edge of each step
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 5'd20, 32'hAAAA0020, 1'b0, 5'd20, 32'hAAAA0020, 1'b0, 1'b0}, // R8
    '{1'b0, 1'b0, 1'b1, 5'd5,  32'h00000505, 1'b1, 5'd5,  32'h00000505, 1'b1, 1'b0}, // R9
    '{1'b1, 1'b1, 1'b1, 5'd20, 32'hBBBB0020, 1'b1, 5'd20, 32'h00000000, 1'b0, 1'b1}, // R5 R8
    '{1'b0, 1'b0, 1'b1, 5'd20, 32'hCCCC0020, 1'b0, 5'd20, 32'hCCCC0020, 1'b0, 1'b1}, // R8
    '{1'b0, 1'b0, 1'b1, 5'd0,  32'hFFFFFFFF, 1'b1, 5'd0,  32'h00000000, 1'b0, 1'b1}, // R2
    '{1'b0, 1'b0, 1'b0, 5'd0,  32'h00000000, 1'b0, 5'd5,  32'h00000505, 1'b1, 1'b1}, // R8
    '{1'b1, 1'b0, 1'b0, 5'd0,  32'h00000000, 1'b0, 5'd20, 32'hBBBB0020, 1'b1, 1'b0}, // R9
    '{1'b0, 1'b0, 1'b1, 5'd31, 32'h31310000, 1'b1, 5'd31, 32'h31310000, 1'b1, 1'b0}, // R8
    '{1'b1, 1'b1, 1'b0, 5'd0,  32'h00000000, 1'b0, 5'd31, 32'h00000000, 1'b0, 1'b1}, // R8
    '{1'b0, 1'b0, 1'b1, 5'd16, 32'h16161616, 1'b0, 5'd16, 32'h16161616, 1'b0, 1'b1}, // R8
    '{1'b1, 1'b0, 1'b0, 5'd0,  32'h00000000, 1'b0, 5'd16, 32'h00000000, 1'b0, 1'b0}, // R8
    '{1'b0, 1'b0, 1'b1, 5'd15, 32'h15151515, 1'b0, 5'd15, 32'h15151515, 1'b0, 1'b0}, // R8
    '{1'b1, 1'b1, 1'b0, 5'd0,  32'h00000000, 1'b0, 5'd15, 32'h15151515, 1'b0, 1'b1}  // R5 R8
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic quiet();
    wr_en_i = 1'b0; intr_take_i = 1'b0; intr_ret_i = 1'b0;
    bank_sw_i = 1'b0; bank_sw_sel_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rd_a_addr_i = 5'd20; rd_b_addr_i = 5'd5;
    #1;
    chk("R1 bank", {31'd0, bank_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 saved", {31'd0, saved_bank_o}, 32'd0);
    chk("R1 data a", rd_a_data_o, 32'd0);
    chk("R1 tag b", {31'd0, rd_b_tag_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      bank_sw_i = VEC[i].sw; bank_sw_sel_i = VEC[i].sel;
      wr_en_i = VEC[i].we; wr_addr_i = VEC[i].wa;
      wr_data_i = VEC[i].wd; wr_tag_i = VEC[i].wt;
      rd_a_addr_i = VEC[i].ra;
      @(negedge clk_i);
      chk($sformatf("R8 vec %0d data", i), rd_a_data_o, VEC[i].ed);
      chk($sformatf("R9 vec %0d tag", i), {31'd0, rd_a_tag_o}, {31'd0, VEC[i].et});
      chk($sformatf("R5 vec %0d bank", i), {31'd0, bank_o}, {31'd0, VEC[i].eb});
      quiet();
    end

    // bank is 1 here: interrupt entry
    intr_take_i = 1'b1;
    rd_a_addr_i = 5'd20; rd_b_addr_i = 5'd31;
    @(negedge clk_i); quiet();
    chk("R3 bank", {31'd0, bank_o}, 32'd0);
    chk("R6 saved", {31'd0, saved_bank_o}, 32'd1);
    chk("R10 port a", rd_a_data_o, 32'hBBBB0020);
    chk("R10 port b", rd_b_data_o, 32'h31310000);

    intr_ret_i = 1'b1;
    @(negedge clk_i); quiet();
    chk("R4 bank", {31'd0, bank_o}, 32'd1);
    chk("R4 read", rd_a_data_o, 32'hCCCC0020);

    // interrupt beats switch
    intr_take_i = 1'b1; bank_sw_i = 1'b1; bank_sw_sel_i = 1'b1;
    @(negedge clk_i); quiet();
    chk("R7 intr over sw", {31'd0, bank_o}, 32'd0);
    chk("R6 saved again", {31'd0, saved_bank_o}, 32'd1);

    // return beats switch
    intr_ret_i = 1'b1; bank_sw_i = 1'b1; bank_sw_sel_i = 1'b0;
    @(negedge clk_i); quiet();
    chk("R7 ret over sw", {31'd0, bank_o}, 32'd1);

    @(negedge clk_i);
    chk("R7 hold", {31'd0, bank_o}, 32'd1);

    // no bypass: same-cycle read sees old value
    wr_en_i = 1'b1; wr_addr_i = 5'd7; wr_data_i = 32'h00000077; wr_tag_i = 1'b1;
    rd_b_addr_i = 5'd7;
    #1;
    chk("R10 no bypass", rd_b_data_o, 32'd0);
    @(negedge clk_i); quiet();
    chk("R10 after edge", rd_b_data_o, 32'h00000077);
    chk("R9 tag written", {31'd0, rd_b_tag_o}, 32'd1);

    // write during interrupt entry uses the old bank (1)
    intr_take_i = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = 5'd18; wr_data_i = 32'h00001818; wr_tag_i = 1'b0;
    rd_a_addr_i = 5'd18;
    @(negedge clk_i); quiet();
    chk("R8 intr write bank0 view", rd_a_data_o, 32'd0);
    intr_ret_i = 1'b1;
    @(negedge clk_i); quiet();
    chk("R8 intr write bank1 view", rd_a_data_o, 32'h00001818);

    // register 0 on both ports
    rd_a_addr_i = 5'd0; rd_b_addr_i = 5'd0;
    #1;
    chk("R2 port a", rd_a_data_o, 32'd0);
    chk("R2 port b", {31'd0, rd_b_tag_o}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule